// File: doc/BRIEF.md
# Sampled Glitch Filter and Edge Request Generator

This block cleans up a bank of slow external signals, such as interrupt or trigger lines, before they reach the rest of the chip. Each channel is examined only on cycles where a sampling strobe is high. A channel's filtered level moves to a new value only after that value has been seen on three strobes in a row. Short spikes are therefore absorbed, and a level that is held long enough always gets through.

Each channel then passes through an edge detector with two independent enable bits, one for upward transitions of the filtered level and one for downward transitions. A transition in an enabled direction produces a request pulse that is one system clock wide. A per-channel bypass control marks a line as a plain input. The filtered level of that line then tracks the raw pin on every clock, with no strobe dependence and no filtering. All channels run in parallel and share only the clock, the reset and the strobe.

Top module: `pin_glitch_edge`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every `level_o` bit and every `irq_o` bit is 0, whatever the raw inputs are.
- R2: With bypass low, a channel's `level_o` changes only at a clock edge where `sample_en` is 1. It takes the raw value sampled at that edge, and only when the last three strobe samples, including that one, all hold that value.
- R3: Clock edges where `sample_en` is 0 neither advance a filtering channel's sample history nor change its `level_o`, however the raw input moves.
- R4: A raw level held for four or more consecutive strobe samples always reaches `level_o`. A level present for only one strobe sample never reaches `level_o`.
- R5: If `level_o` of a channel goes 0→1 at edge k and `rise_en` of that channel is 1 at edge k+1, then `irq_o` of that channel is 1 for exactly the cycle between edges k+1 and k+2.
- R6: If `level_o` goes 1→0 at edge k and `fall_en` is 1 at edge k+1, then `irq_o` pulses for one cycle in the same way. The falling enable is a separate bit from the rising enable.
- R7: With both enables set, a channel requests on every transition. With both cleared, its `irq_o` stays 0.
- R8: With `bypass` high, `level_o` of that channel equals the raw input sampled at the previous clock edge, regardless of `sample_en`, and edge requests still follow R5 and R6.
- R9: Channels are independent. One channel's inputs never affect another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Sampling strobe, one system-clock wide |
| raw_i | input | NCH | Raw external lines, already synchronous to clk |
| bypass_i | input | NCH | 1 = channel is a plain input, with no filtering |
| rise_en_i | input | NCH | Rising-transition request enable per channel |
| fall_en_i | input | NCH | Falling-transition request enable per channel |
| level_o | output | NCH | Filtered (or bypassed) level per channel |
| irq_o | output | NCH | One-cycle request pulse per channel |

## Verification
Within one filtering channel, a new level change can never land on the same cycle as the request pulse from the previous change, because three strobes separate them. Across the bank, however, one channel's rising request and another channel's falling request, or one channel's level update and a neighbour's pulse, regularly fall in the same cycle. The random phase provokes this by giving every channel its own run lengths on a shared strobe and by randomising the enable masks. A bench model computes each channel's level and request separately, and every output bit is compared on every cycle, so a pulse that leaks into or masks a neighbour is reported.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

   // Widest sample history any instance may ask for.
   localparam int unsigned PGF_MAX_MATCH = 8;

   // True when the low `len` bits of `win` all carry the same value.
   function automatic logic uniform_run(input logic [PGF_MAX_MATCH-1:0] win,
                                        input int unsigned len);
      logic same;
      same = 1'b1;
      for (int unsigned i = 1; i < PGF_MAX_MATCH; i++) begin
         if (i < len && win[i] != win[0]) same = 1'b0;
      end
      return same;
   endfunction

endpackage

// File: rtl/pgf_sampler.sv
module pgf_sampler
   import pgf_pkg::*;
#(
   parameter int unsigned MATCH_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_en,
   input  logic raw_in,
   input  logic bypass,
   output logic level_o
);

   logic [MATCH_LEN-1:0]     hist_q;
   logic [MATCH_LEN-1:0]     hist_nx;
   logic [PGF_MAX_MATCH-1:0] win;
   logic                     level_q;
   logic                     settle;

   assign hist_nx = {hist_q[MATCH_LEN-2:0], raw_in};

   always_comb begin
      win                = '0;
      win[MATCH_LEN-1:0] = hist_nx;
      settle             = uniform_run(win, MATCH_LEN) && (hist_nx[0] != level_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q  <= '0;
         level_q <= 1'b0;
      end else if (bypass) begin
         hist_q  <= {MATCH_LEN{raw_in}};
         level_q <= raw_in;
      end else if (sample_en) begin
         hist_q <= hist_nx;
         if (settle) level_q <= hist_nx[0];
      end
   end

   assign level_o = level_q;

   // R2: a filtered change needs a strobe and carries the sampled raw value
   a_r2_change_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(bypass) && level_q != $past(level_q)) |-> ($past(sample_en) && $past(raw_in) == level_q));

   // R3: no strobe, no movement
   a_r3_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(sample_en) && !$past(bypass)) |-> (level_q == $past(level_q) && hist_q == $past(hist_q)));

   // R8: plain-input channel follows the pin one edge later
   a_r8_bypass_follows: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bypass) |-> (level_q == $past(raw_in)));

endmodule

// File: rtl/pgf_edge.sv
module pgf_edge #(
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   input  logic rise_en,
   input  logic fall_en,
   output logic irq_o
);

   logic level_d;
   logic hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d <= 1'b0;
      else        level_d <= level_i;
   end

   assign hit = (level_i & ~level_d & rise_en) | (~level_i & level_d & fall_en);

   generate
      if (IRQ_REGISTERED) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= hit;
         end
         assign irq_o = irq_q;

         // R7: no enables, no request
         a_r7_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(rise_en) && !$past(fall_en)) |-> !irq_q);

         // R5: a request after an upward move needs the rising enable
         a_r5_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_q && level_d) |-> $past(rise_en));

         // R6: a request after a downward move needs the falling enable
         a_r6_fall_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_q && !level_d) |-> $past(fall_en));
      end else begin : g_comb
         assign irq_o = hit;
      end
   endgenerate

endmodule

// File: rtl/pin_glitch_edge.sv
module pin_glitch_edge
   import pgf_pkg::*;
#(
   parameter int unsigned NCH            = 8,
   parameter int unsigned MATCH_LEN      = 3,
   parameter bit          IRQ_REGISTERED = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sample_en,
   input  logic [NCH-1:0] raw_i,
   input  logic [NCH-1:0] bypass_i,
   input  logic [NCH-1:0] rise_en_i,
   input  logic [NCH-1:0] fall_en_i,
   output logic [NCH-1:0] level_o,
   output logic [NCH-1:0] irq_o
);

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("pin_glitch_edge: NCH must be at least 1");
      end
      if (MATCH_LEN < 2 || MATCH_LEN > PGF_MAX_MATCH) begin : g_bad_match
         $error("pin_glitch_edge: MATCH_LEN out of range");
      end
   endgenerate

   logic [NCH-1:0] lvl;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         pgf_sampler #(.MATCH_LEN(MATCH_LEN)) u_smp (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample_en(sample_en),
            .raw_in   (raw_i[c]),
            .bypass   (bypass_i[c]),
            .level_o  (lvl[c])
         );
         pgf_edge #(.IRQ_REGISTERED(IRQ_REGISTERED)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .level_i(lvl[c]),
            .rise_en(rise_en_i[c]),
            .fall_en(fall_en_i[c]),
            .irq_o  (irq_o[c])
         );
      end
   endgenerate

   assign level_o = lvl;

endmodule

// File: tb/pin_glitch_edge_tb_top.sv
module pin_glitch_edge_tb_top;

   localparam int NCH = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           sample_en = 1'b0;
   logic [NCH-1:0] raw = '0, byp = '0, rise = '0, fall = '0;
   logic [NCH-1:0] level_o, irq_o;

   always #2 clk = ~clk;

   pin_glitch_edge #(.NCH(NCH)) dut_i (
      .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .raw_i(raw),
      .bypass_i(byp), .rise_en_i(rise), .fall_en_i(fall),
      .level_o(level_o), .irq_o(irq_o)
   );

   // Bench model built from the requirements
   logic [2:0]     m_hist [NCH];
   logic [NCH-1:0] m_lvl = '0, m_lvl_d = '0, m_irq = '0;
   int             checks = 0, fails = 0;
   int             irq_cnt [NCH];
   bit             done = 0;

   function automatic logic irq_expect(logic l, logic ld, logic r, logic f);
      return (l & ~ld & r) | (~l & ld & f);
   endfunction

   task automatic model_reset();
      for (int c = 0; c < NCH; c++) m_hist[c] = 3'b000;
      m_lvl = '0; m_lvl_d = '0; m_irq = '0;
   endtask

   task automatic model_advance();
      for (int c = 0; c < NCH; c++) begin
         logic [2:0] h;
         m_irq[c]   = irq_expect(m_lvl[c], m_lvl_d[c], rise[c], fall[c]);
         m_lvl_d[c] = m_lvl[c];
         if (byp[c]) begin
            m_hist[c] = {3{raw[c]}};
            m_lvl[c]  = raw[c];
         end else if (sample_en) begin
            h = {m_hist[c][1:0], raw[c]};
            m_hist[c] = h;
            if ((h == 3'b111 || h == 3'b000) && h[0] != m_lvl[c]) m_lvl[c] = h[0];
         end
      end
   endtask

   task automatic check_vec(string req, string what, logic [NCH-1:0] act, logic [NCH-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic check_int(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // One clock: inputs already set; predict, clock, compare away from the edge
   task automatic step(string req);
      model_advance();
      @(posedge clk);
      @(negedge clk);
      check_vec(req, "level_o", level_o, m_lvl);
      check_vec(req, "irq_o", irq_o, m_irq);
      for (int c = 0; c < NCH; c++) if (irq_o[c]) irq_cnt[c]++;
   endtask

   task automatic clear_counts();
      for (int c = 0; c < NCH; c++) irq_cnt[c] = 0;
   endtask

   task automatic strobes(string req, int n, int gap);
      for (int i = 0; i < n * gap; i++) begin
         sample_en = (i % gap == 0);
         step(req);
      end
      sample_en = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      if (!done) begin
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int run_left [NCH];
      void'($urandom(32'd24681));
      model_reset();
      clear_counts();

      // R1: reset holds everything low even with active inputs
      raw = '1; sample_en = 1'b1; rise = '1; fall = '1;
      repeat (5) @(negedge clk);
      check_vec("R1", "level_o in reset", level_o, '0);
      check_vec("R1", "irq_o in reset", irq_o, '0);
      raw = '0; sample_en = 1'b0; rise = '0; fall = '0;
      @(negedge clk);
      rst_n = 1'b1;
      step("R1");
      check_vec("R1", "level_o after release", level_o, '0);

      // R2 / R5: channel 0 rising with rising enable, strobe every third clock
      rise = 8'h01; raw[0] = 1'b1; clear_counts();
      strobes("R2", 5, 3);
      check_vec("R2", "ch0 level after run", {7'd0, level_o[0]}, 8'h01);
      check_int("R5", "ch0 rising pulses", irq_cnt[0], 1);

      // R3: channel 1 raw high without strobes never settles
      raw[1] = 1'b1;
      for (int i = 0; i < 10; i++) step("R3");
      check_vec("R3", "ch1 level without strobes", {7'd0, level_o[1]}, 8'h00);
      raw[1] = 1'b0;
      strobes("R3", 3, 1);

      // R4: one-sample glitch on channel 2 rejected, four-sample run accepted
      raw[2] = 1'b1; sample_en = 1'b1; step("R4");
      raw[2] = 1'b0; sample_en = 1'b0; step("R4");
      strobes("R4", 4, 2);
      check_vec("R4", "ch2 after one-sample glitch", {7'd0, level_o[2]}, 8'h00);
      raw[2] = 1'b1;
      strobes("R4", 4, 2);
      check_vec("R4", "ch2 after four-sample run", {7'd0, level_o[2]}, 8'h01);

      // R6: channel 0 falling with only the falling enable
      rise = 8'h00; fall = 8'h01; clear_counts();
      raw[0] = 1'b0;
      strobes("R6", 5, 2);
      check_int("R6", "ch0 falling pulses", irq_cnt[0], 1);
      raw[0] = 1'b1;
      strobes("R6", 5, 2);
      check_int("R6", "ch0 no request on rise", irq_cnt[0], 1);

      // R7: channel 3 both enables, channel 4 none
      rise = 8'h08; fall = 8'h08; clear_counts();
      raw[3] = 1'b1; raw[4] = 1'b1;
      strobes("R7", 5, 2);
      raw[3] = 1'b0; raw[4] = 1'b0;
      strobes("R7", 5, 2);
      check_int("R7", "ch3 pulses both edges", irq_cnt[3], 2);
      check_int("R7", "ch4 pulses disabled", irq_cnt[4], 0);

      // R8: channel 5 bypassed, toggles every clock with no strobe
      byp = 8'h20; rise = 8'h20; fall = 8'h00; clear_counts();
      for (int i = 0; i < 8; i++) begin
         raw[5] = ~raw[5];
         step("R8");
      end
      check_int("R8", "ch5 bypass rising pulses", irq_cnt[5], 4);
      raw[5] = 1'b0; step("R8");
      byp = '0; raw = '0;
      strobes("R8", 6, 1);

      // R9: random runs per channel (1 or 4..6 samples), shared strobe
      for (int c = 0; c < NCH; c++) run_left[c] = 4 + int'($urandom % 3);
      for (int i = 0; i < 3000; i++) begin
         if (i % 64 == 0) begin
            rise = NCH'($urandom);
            fall = NCH'($urandom);
         end
         sample_en = ($urandom % 3 == 0);
         step("R9");
         if (sample_en) begin
            for (int c = 0; c < NCH; c++) begin
               run_left[c]--;
               if (run_left[c] == 0) begin
                  int r;
                  raw[c] = ~raw[c];
                  r = int'($urandom % 4);
                  run_left[c] = (r == 0) ? 1 : 3 + r;
               end
            end
         end
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule